// File: doc/BRIEF.md
# Transmit FIFO Start-Threshold Controller

This block holds outgoing frames in a byte-wide queue between a host that writes bytes (each tagged with an end-of-frame flag) and a MAC transmitter that pulls them out. It decides when the transmitter may begin pulling the frame at the head of the queue. In cut-through mode the frame starts once more bytes of it are queued than a programmed threshold allows, or as soon as the whole frame is queued if it is shorter. In store-and-forward mode the frame starts only after its final byte is queued, and the threshold setting has no effect.

A self-clearing flush command empties the queue and resets its bookkeeping. A frame that the transmitter has already started is not recalled. Its next read finds no data, so it ends as an underflow and is treated as a runt that has been sent. The flush flag stays set until three things hold: the queue is empty, the transmitter is idle, and the host has acknowledged every pending completed-frame status. Control writes made while the flush flag is set are dropped, and each one is reported with an error pulse. A change of mode takes effect only while no frame is being sent.

Top module: `txq_start_ctrl`

## Requirements
- R1: In cut-through mode, with no complete frame queued, `tx_go` rises one cycle after the write that makes the queued byte count strictly greater than the threshold selected by `cfg_thr`. The codes map as 7→16, 6→24, 5→32, 4→40, 0→64, 1→128, 2→192 and 3→256 bytes.
- R2: In cut-through mode, a frame whose final byte is queued starts even when its length is at or below the threshold.
- R3: In store-and-forward mode, `tx_go` rises only after the frame's final byte (`wr_last`=1) is queued, whatever the value of `cfg_thr`.
- R4: A mode written while a frame is being sent is held back. `sf_mode` changes only in the second cycle after the frame ends, and stays unchanged while sending.
- R5: Bytes leave in write order, with their end-of-frame flag intact. `tx_go` falls in the cycle after the byte flagged `rd_last` is read.
- R6: A control write with `cfg_flush`=1 discards all queued bytes. `flush_busy` reads 1 from the next cycle on, and `wr_ready` is 0 while `flush_busy` is 1.
- R7: `flush_busy` clears only once the queue is empty, no frame is being sent and no completed-frame status is pending. It clears one cycle after these conditions first hold.
- R8: If a flush hits a frame in progress, that frame's next read raises `rd_underflow`, ends the frame (`tx_go` falls) and posts one completed-frame status.
- R9: A control write while `flush_busy`=1 has no effect on mode, threshold or flush, and it raises `cfg_err` for exactly one cycle, one cycle later.
- R10: In cut-through mode, a read with `tx_go`=1 and no data queued raises `rd_underflow` for one cycle, consumes nothing and keeps the frame open.
- R11: Every frame that ends posts one status. `st_valid` is 1 while any status is pending, and each `st_ack` cycle retires one status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host byte valid |
| wr_data | input | 8 | Host byte |
| wr_last | input | 1 | Host byte is the last byte of its frame |
| wr_ready | output | 1 | Queue can accept a byte |
| tx_go | output | 1 | Transmitter may read the head frame |
| rd_en | input | 1 | Transmitter reads one byte |
| rd_data | output | 8 | Head byte |
| rd_last | output | 1 | Head byte ends its frame |
| rd_underflow | output | 1 | A read found no data (pulse) |
| cfg_wr | input | 1 | Control write strobe |
| cfg_sf | input | 1 | Store-and-forward mode value |
| cfg_thr | input | 3 | Threshold code |
| cfg_flush | input | 1 | Flush request |
| cfg_err | output | 1 | Control write dropped during flush (pulse) |
| flush_busy | output | 1 | Flush in progress |
| sf_mode | output | 1 | Mode in effect |
| st_valid | output | 1 | Completed-frame status pending |
| st_ack | input | 1 | Host accepts one status |

## Verification
The start decision sits behind one state register. `tx_go` is therefore due in the second sampling point after the write that triggers it, and the bench checks `tx_go` one full cycle after each push returns. The following are visible at the first sampling point after their edge: the underflow pulse, the control error pulse, status posting and flush set. The following show one edge later: flush clearing, because it waits on the status counter, and a mode update, because it waits for the idle state. The bench waits one extra cycle for exactly those cases. All stimulus is applied on the falling edge, and every comparison is made on a falling edge.

// File: rtl/txq_pkg.sv
package txq_pkg;

   typedef enum logic [1:0] {
      TXS_IDLE  = 2'd0,
      TXS_SEND  = 2'd1,
      TXS_DRAIN = 2'd2
   } txs_state_e;

   // threshold code to byte count; the order is not monotonic
   function automatic logic [8:0] thr_bytes(input logic [2:0] code);
      logic [8:0] b;
      case (code)
         3'd0: b = 9'd64;
         3'd1: b = 9'd128;
         3'd2: b = 9'd192;
         3'd3: b = 9'd256;
         3'd4: b = 9'd40;
         3'd5: b = 9'd32;
         3'd6: b = 9'd24;
         default: b = 9'd16;
      endcase
      return b;
   endfunction

endpackage

// File: rtl/txq_store.sv
module txq_store #(
   parameter int DW    = 8,
   parameter int DEPTH = 2048,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic [DW-1:0] push_data,
   input  logic          push_last,
   input  logic          pop,
   output logic [DW-1:0] head_data,
   output logic          head_last,
   output logic          empty,
   output logic          full,
   output logic [CW-1:0] level,
   output logic [CW-1:0] frames
);

   logic [DW:0]   mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [CW-1:0] lvl_q, frm_q;
   logic          pop_last;

   assign empty     = (lvl_q == '0);
   assign full      = (lvl_q == CW'(DEPTH));
   assign level     = lvl_q;
   assign frames    = frm_q;
   assign head_data = mem[rp][DW-1:0];
   assign head_last = mem[rp][DW];
   assign pop_last  = pop & mem[rp][DW];

   always_ff @(posedge clk) begin
      if (push && !clr) mem[wp] <= {push_last, push_data};
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         wp    <= '0;
         rp    <= '0;
         lvl_q <= '0;
         frm_q <= '0;
      end else begin
         if (push) wp <= wp + 1'b1;
         if (pop)  rp <= rp + 1'b1;
         case ({push, pop})
            2'b10:   lvl_q <= lvl_q + 1'b1;
            2'b01:   lvl_q <= lvl_q - 1'b1;
            default: lvl_q <= lvl_q;
         endcase
         case ({push & push_last, pop_last})
            2'b10:   frm_q <= frm_q + 1'b1;
            2'b01:   frm_q <= frm_q - 1'b1;
            default: frm_q <= frm_q;
         endcase
      end
   end

   a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   a_r10_pop_guard: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);

endmodule

// File: rtl/txq_start_fsm.sv
module txq_start_fsm
   import txq_pkg::*;
#(
   parameter int CW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sf_mode,
   input  logic [2:0]    thr_code,
   input  logic [CW-1:0] level,
   input  logic [CW-1:0] frames,
   input  logic          empty,
   input  logic          flush_go,
   input  logic          rd_en,
   input  logic          head_last,
   output logic          tx_go,
   output logic          pop,
   output logic          frame_done,
   output logic          idle,
   output logic          rd_underflow
);

   txs_state_e    st_q, st_d;
   logic [CW-1:0] thr_w;
   logic          start, starve;

   assign thr_w  = CW'(thr_bytes(thr_code));
   assign start  = !flush_go && ((frames != '0) || (!sf_mode && (level > thr_w)));
   assign tx_go  = (st_q != TXS_IDLE);
   assign idle   = (st_q == TXS_IDLE);
   assign pop    = rd_en && (st_q == TXS_SEND) && !empty;
   assign starve = rd_en && tx_go && ((st_q == TXS_DRAIN) || empty);
   assign frame_done = (pop && head_last) || (rd_en && (st_q == TXS_DRAIN));

   always_comb begin
      st_d = st_q;
      case (st_q)
         TXS_IDLE:  if (start) st_d = TXS_SEND;
         TXS_SEND:  if (pop && head_last) st_d = TXS_IDLE;
                    else if (flush_go) st_d = TXS_DRAIN;
         TXS_DRAIN: if (rd_en) st_d = TXS_IDLE;
         default:   st_d = TXS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q         <= TXS_IDLE;
         rd_underflow <= 1'b0;
      end else begin
         st_q         <= st_d;
         rd_underflow <= starve;
      end
   end

   a_r3_sf_waits_frame: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_go) |-> $past((frames != '0) || !sf_mode));

endmodule

// File: rtl/txq_flush_ctl.sv
module txq_flush_ctl #(
   parameter int SW = 12
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cfg_wr,
   input  logic       cfg_sf,
   input  logic [2:0] cfg_thr,
   input  logic       cfg_flush,
   input  logic       idle,
   input  logic       empty,
   input  logic       frame_done,
   input  logic       st_ack,
   output logic       sf_mode,
   output logic [2:0] thr_code,
   output logic       flush_busy,
   output logic       flush_go,
   output logic       cfg_err,
   output logic       st_valid
);

   logic          accept, sf_shadow, retire;
   logic [SW-1:0] st_cnt;

   assign accept   = cfg_wr && !flush_busy;
   assign flush_go = accept && cfg_flush;
   assign retire   = st_ack && (st_cnt != '0);
   assign st_valid = (st_cnt != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sf_shadow  <= 1'b0;
         sf_mode    <= 1'b0;
         thr_code   <= 3'd0;
         flush_busy <= 1'b0;
         cfg_err    <= 1'b0;
         st_cnt     <= '0;
      end else begin
         if (accept) begin
            sf_shadow <= cfg_sf;
            thr_code  <= cfg_thr;
         end
         if (idle) sf_mode <= sf_shadow;
         cfg_err <= cfg_wr && flush_busy;
         if (flush_go)
            flush_busy <= 1'b1;
         else if (flush_busy && idle && empty && (st_cnt == '0))
            flush_busy <= 1'b0;
         case ({frame_done, retire})
            2'b10:   st_cnt <= st_cnt + 1'b1;
            2'b01:   st_cnt <= st_cnt - 1'b1;
            default: st_cnt <= st_cnt;
         endcase
      end
   end

   a_r4_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!idle) |-> $stable(sf_mode));
   a_r7_flush_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flush_busy) |-> $past(idle && empty && (st_cnt == '0)));
   a_r9_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> $past(cfg_wr && flush_busy));

endmodule

// File: rtl/txq_start_ctrl.sv
module txq_start_ctrl #(
   parameter int DW    = 8,
   parameter int DEPTH = 2048
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_valid,
   input  logic [DW-1:0] wr_data,
   input  logic          wr_last,
   output logic          wr_ready,
   output logic          tx_go,
   input  logic          rd_en,
   output logic [DW-1:0] rd_data,
   output logic          rd_last,
   output logic          rd_underflow,
   input  logic          cfg_wr,
   input  logic          cfg_sf,
   input  logic [2:0]    cfg_thr,
   input  logic          cfg_flush,
   output logic          cfg_err,
   output logic          flush_busy,
   output logic          sf_mode,
   output logic          st_valid,
   input  logic          st_ack
);

   localparam int AW = $clog2(DEPTH);
   localparam int CW = AW + 1;

   generate
      if (DEPTH <= 256 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two above the largest threshold");
      end
      if (DW < 1) begin : g_bad_width
         $error("DW must be at least 1");
      end
   endgenerate

   logic          push, pop, clr, empty, full, idle, frame_done;
   logic [CW-1:0] level, frames;
   logic [2:0]    thr_code;

   assign wr_ready = !full && !flush_busy;
   assign push     = wr_valid && wr_ready;

   txq_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .push      (push),
      .push_data (wr_data),
      .push_last (wr_last),
      .pop       (pop),
      .head_data (rd_data),
      .head_last (rd_last),
      .empty     (empty),
      .full      (full),
      .level     (level),
      .frames    (frames)
   );

   txq_start_fsm #(.CW(CW)) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .sf_mode      (sf_mode),
      .thr_code     (thr_code),
      .level        (level),
      .frames       (frames),
      .empty        (empty),
      .flush_go     (clr),
      .rd_en        (rd_en),
      .head_last    (rd_last),
      .tx_go        (tx_go),
      .pop          (pop),
      .frame_done   (frame_done),
      .idle         (idle),
      .rd_underflow (rd_underflow)
   );

   txq_flush_ctl #(.SW(CW)) u_flush (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_wr     (cfg_wr),
      .cfg_sf     (cfg_sf),
      .cfg_thr    (cfg_thr),
      .cfg_flush  (cfg_flush),
      .idle       (idle),
      .empty      (empty),
      .frame_done (frame_done),
      .st_ack     (st_ack),
      .sf_mode    (sf_mode),
      .thr_code   (thr_code),
      .flush_busy (flush_busy),
      .flush_go   (clr),
      .cfg_err    (cfg_err),
      .st_valid   (st_valid)
   );

endmodule

// File: tb/txq_start_ctrl_bench.sv
module txq_start_ctrl_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_valid = 1'b0, wr_last = 1'b0, rd_en = 1'b0;
   logic [7:0] wr_data = 8'd0;
   logic       cfg_wr = 1'b0, cfg_sf = 1'b0, cfg_flush = 1'b0, st_ack = 1'b0;
   logic [2:0] cfg_thr = 3'd0;
   logic       wr_ready, tx_go, rd_last, rd_underflow, cfg_err, flush_busy, sf_mode, st_valid;
   logic [7:0] rd_data;

   int n_chk = 0;
   int n_bad = 0;
   logic [8:0] exp_q[$];

   always #5 clk = ~clk;

   txq_start_ctrl u_txq_start_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data), .wr_last(wr_last),
      .wr_ready(wr_ready), .tx_go(tx_go), .rd_en(rd_en), .rd_data(rd_data), .rd_last(rd_last),
      .rd_underflow(rd_underflow), .cfg_wr(cfg_wr), .cfg_sf(cfg_sf), .cfg_thr(cfg_thr),
      .cfg_flush(cfg_flush), .cfg_err(cfg_err), .flush_busy(flush_busy), .sf_mode(sf_mode),
      .st_valid(st_valid), .st_ack(st_ack)
   );

   function automatic int want_thr(input logic [2:0] c);
      case (c)
         3'd7: return 16;
         3'd6: return 24;
         3'd5: return 32;
         3'd4: return 40;
         3'd0: return 64;
         3'd1: return 128;
         3'd2: return 192;
         default: return 256;
      endcase
   endfunction

   task automatic chk(input string req, input int act, input int expv);
      n_chk++;
      if (act != expv) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic cfg(input logic sf, input logic [2:0] thr, input logic fl);
      cfg_wr = 1'b1; cfg_sf = sf; cfg_thr = thr; cfg_flush = fl;
      @(posedge clk); @(negedge clk);
      cfg_wr = 1'b0; cfg_flush = 1'b0;
   endtask

   task automatic push(input logic last);
      logic [7:0] d;
      d = 8'($urandom);
      wr_valid = 1'b1; wr_data = d; wr_last = last;
      @(posedge clk); @(negedge clk);
      wr_valid = 1'b0; wr_last = 1'b0;
      exp_q.push_back({last, d});
   endtask

   task automatic pop(input string req);
      logic [8:0] e;
      e = exp_q.pop_front();
      chk({req, " go"}, int'(tx_go), 1);
      chk({req, " data"}, int'(rd_data), int'(e[7:0]));
      chk({req, " last"}, int'(rd_last), int'(e[8]));
      rd_en = 1'b1;
      @(posedge clk); @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic raw_read();
      rd_en = 1'b1;
      @(posedge clk); @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic ack();
      st_ack = 1'b1;
      @(posedge clk); @(negedge clk);
      st_ack = 1'b0;
   endtask

   task automatic drain_ack(input string req);
      while (exp_q.size() > 0) pop(req);
      chk("R11 status posted", int'(st_valid), 1);
      chk("R5 go falls after last", int'(tx_go), 0);
      ack();
      chk("R11 status retired", int'(st_valid), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      report();
   end

   initial begin
      logic [2:0] codes [5];
      void'($urandom(32'h5EED_0042));
      codes = '{3'd7, 3'd6, 3'd5, 3'd4, 3'd0};
      wait_n(3);
      rst_n = 1'b1;
      wait_n(1);
      // reset state
      chk("R6 reset wr_ready", int'(wr_ready), 1);
      chk("R1 reset tx_go", int'(tx_go), 0);
      chk("R7 reset flush_busy", int'(flush_busy), 0);
      chk("R11 reset st_valid", int'(st_valid), 0);
      chk("R4 reset sf_mode", int'(sf_mode), 0);

      // R1: threshold exceeded by one byte for several codes
      foreach (codes[k]) begin
         cfg(1'b0, codes[k], 1'b0);
         wait_n(1);
         for (int i = 0; i < want_thr(codes[k]); i++) push(1'b0);
         wait_n(1);
         chk("R1 at threshold", int'(tx_go), 0);
         push(1'b0);
         wait_n(1);
         chk("R1 above threshold", int'(tx_go), 1);
         push(1'b1);
         drain_ack("R5");
      end

      // R2: short complete frame
      cfg(1'b0, 3'd0, 1'b0);
      wait_n(1);
      for (int i = 0; i < 4; i++) push(1'b0);
      wait_n(1);
      chk("R2 partial short frame", int'(tx_go), 0);
      push(1'b1);
      wait_n(1);
      chk("R2 short frame starts", int'(tx_go), 1);
      drain_ack("R2");

      // R3: store-and-forward ignores threshold
      cfg(1'b1, 3'd7, 1'b0);
      wait_n(2);
      for (int i = 0; i < 100; i++) push(1'b0);
      wait_n(1);
      chk("R3 no start without last", int'(tx_go), 0);
      push(1'b1);
      wait_n(1);
      chk("R3 start on whole frame", int'(tx_go), 1);
      drain_ack("R3");

      // R4: mode change during a frame is held back
      cfg(1'b0, 3'd7, 1'b0);
      wait_n(2);
      for (int i = 0; i < 17; i++) push(1'b0);
      wait_n(1);
      chk("R4 frame running", int'(tx_go), 1);
      cfg(1'b1, 3'd7, 1'b0);
      wait_n(1);
      chk("R4 mode held while sending", int'(sf_mode), 0);
      push(1'b1);
      while (exp_q.size() > 0) pop("R4");
      chk("R4 mode still held at frame end", int'(sf_mode), 0);
      wait_n(1);
      chk("R4 mode applied when idle", int'(sf_mode), 1);
      ack();

      // R10: cut-through underflow
      cfg(1'b0, 3'd7, 1'b0);
      wait_n(2);
      for (int i = 0; i < 17; i++) push(1'b0);
      wait_n(1);
      while (exp_q.size() > 0) pop("R10");
      raw_read();
      chk("R10 underflow pulse", int'(rd_underflow), 1);
      chk("R10 frame stays open", int'(tx_go), 1);
      wait_n(1);
      chk("R10 pulse one cycle", int'(rd_underflow), 0);
      push(1'b1);
      drain_ack("R10");

      // R6/R8/R9/R7: flush hitting a frame in progress
      for (int i = 0; i < 17; i++) push(1'b0);
      wait_n(1);
      for (int i = 0; i < 3; i++) pop("R8");
      cfg(1'b0, 3'd7, 1'b1);
      exp_q.delete();
      chk("R6 flush reads busy", int'(flush_busy), 1);
      chk("R6 writes blocked", int'(wr_ready), 0);
      raw_read();
      chk("R8 underflow after flush", int'(rd_underflow), 1);
      chk("R8 frame ends", int'(tx_go), 0);
      chk("R8 status posted", int'(st_valid), 1);
      cfg(1'b1, 3'd0, 1'b0);
      chk("R9 error pulse", int'(cfg_err), 1);
      wait_n(1);
      chk("R9 error one cycle", int'(cfg_err), 0);
      wait_n(1);
      chk("R9 mode unchanged", int'(sf_mode), 0);
      chk("R7 busy while status pending", int'(flush_busy), 1);
      ack();
      chk("R7 busy at ack", int'(flush_busy), 1);
      wait_n(1);
      chk("R7 flush self-clears", int'(flush_busy), 0);
      chk("R6 writes reopen", int'(wr_ready), 1);
      // old bytes discarded: a new short frame comes out intact
      for (int i = 0; i < 2; i++) push(1'b0);
      push(1'b1);
      wait_n(1);
      drain_ack("R6");

      // R7: flush while idle with nothing pending clears one cycle later
      cfg(1'b0, 3'd7, 1'b1);
      chk("R7 idle flush set", int'(flush_busy), 1);
      wait_n(1);
      chk("R7 idle flush cleared", int'(flush_busy), 0);

      // random frames
      for (int f = 0; f < 30; f++) begin
         logic       sf;
         logic [2:0] code;
         int         len;
         sf   = 1'($urandom);
         code = 3'($urandom);
         len  = 1 + int'($urandom % 300);
         cfg(sf, code, 1'b0);
         wait_n(2);
         for (int i = 0; i < len; i++) begin
            logic last;
            int   expg;
            last = (i == len - 1);
            push(last);
            wait_n(1);
            expg = (last || (!sf && (i + 1) > want_thr(code))) ? 1 : 0;
            chk(sf ? "R3 random start" : "R1 random start", int'(tx_go), expg);
         end
         drain_ack("R5 random");
      end

      report();
   end

endmodule